// File: doc/BRIEF.md
# Serial Sample Port with Frame Generation

This block is the input side of one transmit channel. It is the master of a three-wire serial link toward a host processor. It makes the serial bit clock by dividing the master clock and drives a frame pulse at the channel's input sample rate. It then shifts in one 32-bit word per frame on the data line. The word is split into an in-phase and a quadrature 16-bit two's-complement sample. Each completed pair appears on parallel outputs with a single-cycle strobe in the master clock domain.

Sample timing comes from a programmable period in master clocks, the channel's interpolation factor. A phase accumulator marks each period boundary. The frame pulse is launched on the first serial clock rising edge at or after that boundary. When the period is not a whole number of serial clock periods, the gap between frames alternates between two lengths one serial clock apart, and the long-run frame rate equals the sample rate exactly. A sleep input silences framing and capture. The serial clock keeps running while asleep.

Top module: `serial_sample_port`

## Requirements
- R1: While `rst_n` is low, `sclk` is 0. On the first `clk` rising edge after `rst_n` goes high, `sclk` goes to 1.
- R2: Each level of `sclk` lasts exactly `sclk_div`+1 master clocks, so one serial clock period is 2*(`sclk_div`+1) master clocks. That is 1/2 to 1/64 of the master clock for the 5-bit divider.
- R3: `sdfs` changes only on master clock edges where `sclk` rises. Each frame pulse stays high for exactly one serial clock period.
- R4: Period boundaries fall every `interp_period` master clocks, the first on the first edge after reset release. Frame b starts on the first `sclk` rising edge at or after boundary b. Counting that first edge as cycle 1, frame b starts at cycle 1 + ceil(b*P/T)*T, where P is the period and T is the serial clock period. With a non-integer P/T, the frame gap alternates between two values.
- R5: While `sleep` is high, `sdfs` and `samp_valid` stay 0 from the next master clock on.
- R6: The first data bit is taken on the second `sclk` rising edge after `sdfs` went high. The 32 bits arrive most significant bit first. The first 16 bits form `samp_i` and the last 16 bits form `samp_q`.
- R7: `samp_valid` is high for exactly one master clock, in the cycle right after the edge that takes the 32nd bit. It is never high at any other time.
- R8: `sclk` rising edges after the 32nd bit of a frame are ignored. `samp_i` and `samp_q` change only together with `samp_valid`.
- R9: While in reset, `sdfs`, `samp_valid`, `samp_i` and `samp_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low channel reset |
| sleep | input | 1 | Channel sleep; holds framing and capture idle |
| sclk_div | input | 5 | Serial clock divider value |
| interp_period | input | 16 | Input sample period in master clocks |
| sdin | input | 1 | Serial data from the host |
| sclk | output | 1 | Serial bit clock |
| sdfs | output | 1 | Frame pulse, one serial clock wide |
| samp_i | output | 16 | Captured in-phase sample |
| samp_q | output | 16 | Captured quadrature sample |
| samp_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A corrupted divider count shows up within one serial clock half-period as a level of `sclk` that is too long or too short. A corrupted phase accumulator or a lost pending request moves a frame pulse away from its computed cycle, and the first frame after the fault exposes it. Capture faults come from a wrong bit counter or a wrong arming edge. They show at the strobe of that same frame as a shifted or misplaced word, or as a strobe in the wrong cycle. Data that leaks in after the 32nd bit changes the held samples within the next few serial clocks, with no strobe.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             sclk_rise
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } clkgen_s;

    clkgen_s st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == '0);
        if (tick) begin
            st_d.cnt = div;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk      = st_q.lvl;
    assign sclk_rise = tick & ~st_q.lvl;

endmodule

// File: rtl/ssp_framer.sv
module ssp_framer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [PER_W-1:0] period,
    input  logic             sclk_rise,
    output logic             sdfs
);

    localparam int EXT_W = PER_W + 1;

    typedef struct packed {
        logic [PER_W-1:0] acc;
        logic             pending;
        logic             pulse;
    } framer_s;

    framer_s          st_d, st_q;
    logic             boundary;
    logic             wrap;
    logic             request;
    logic [EXT_W-1:0] acc_next;

    always_comb begin
        st_d     = st_q;
        boundary = (st_q.acc == '0);
        acc_next = {1'b0, st_q.acc} + 1'b1;
        wrap     = (acc_next >= {1'b0, period});
        request  = st_q.pending | boundary;

        st_d.acc = wrap ? '0 : acc_next[PER_W-1:0];

        if (sclk_rise) begin
            st_d.pulse   = request;
            st_d.pending = 1'b0;
        end else begin
            st_d.pending = request;
        end

        if (sleep) begin
            st_d.acc     = '0;
            st_d.pending = 1'b0;
            st_d.pulse   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdfs = st_q.pulse;

endmodule

// File: rtl/ssp_capture.sv
module ssp_capture
    import ssp_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sclk_rise,
    input  logic              sdfs,
    input  logic              sdin,
    output logic [HALF_W-1:0] samp_i,
    output logic [HALF_W-1:0] samp_q,
    output logic              samp_valid
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        cap_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [HALF_W-1:0] i;
        logic [HALF_W-1:0] q;
        logic              valid;
    } capture_s;

    capture_s          st_d, st_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        shifted    = {st_q.sh[WORD_W-2:0], sdin};

        if (sclk_rise) begin
            if (sdfs) begin
                st_d.state = CAP_RUN;
                st_d.cnt   = '0;
            end else if (st_q.state == CAP_RUN) begin
                st_d.sh = shifted;
                if (st_q.cnt == LAST_BIT) begin
                    st_d.i     = shifted[WORD_W-1:HALF_W];
                    st_d.q     = shifted[HALF_W-1:0];
                    st_d.valid = 1'b1;
                    st_d.state = CAP_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        if (sleep) begin
            st_d.state = CAP_IDLE;
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_i     = st_q.i;
    assign samp_q     = st_q.q;
    assign samp_valid = st_q.valid;

endmodule

// File: rtl/serial_sample_port.sv
module serial_sample_port #(
    parameter int DIV_W  = 5,
    parameter int PER_W  = 16,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [DIV_W-1:0]  sclk_div,
    input  logic [PER_W-1:0]  interp_period,
    input  logic              sdin,
    output logic              sclk,
    output logic              sdfs,
    output logic [HALF_W-1:0] samp_i,
    output logic [HALF_W-1:0] samp_q,
    output logic              samp_valid
);

    logic sclk_rise;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (sclk_div),
        .sclk      (sclk),
        .sclk_rise (sclk_rise)
    );

    ssp_framer #(.PER_W(PER_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .period    (interp_period),
        .sclk_rise (sclk_rise),
        .sdfs      (sdfs)
    );

    ssp_capture #(.HALF_W(HALF_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .sclk_rise  (sclk_rise),
        .sdfs       (sdfs),
        .sdin       (sdin),
        .samp_i     (samp_i),
        .samp_q     (samp_q),
        .samp_valid (samp_valid)
    );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DIV_W  = 5,
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic [DIV_W-1:0]  sclk_div,
    input logic              sclk,
    input logic              sdfs,
    input logic [HALF_W-1:0] samp_i,
    input logic [HALF_W-1:0] samp_q,
    input logic              samp_valid
);

    localparam int RUN_W = DIV_W + 3;

    logic [RUN_W-1:0] run_q;
    logic             prev_q;
    logic             seen_q;
    logic             edge_now;

    assign edge_now = (sclk != prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= sclk;
            if (edge_now) begin
                run_q  <= RUN_W'(1);
                seen_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_sclk_idle_R1: assert (sclk == 1'b0)
                else $error("sclk high during reset");
        end
    end

    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && edge_now) |-> (run_q == RUN_W'(sclk_div) + 1'b1));

    assert_sdfs_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdfs) |-> $rose(sclk));

    assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!sdfs && !samp_valid));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> !samp_valid);

    assert_hold_samples_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(samp_i) || !$stable(samp_q)) |-> samp_valid);

endmodule

bind serial_sample_port ssp_checker #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_ssp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .sclk_div   (sclk_div),
    .sclk       (sclk),
    .sdfs       (sdfs),
    .samp_i     (samp_i),
    .samp_q     (samp_q),
    .samp_valid (samp_valid)
);

// File: tb/tb_serial_sample_port.sv
`timescale 1ns/1ps
module tb_serial_sample_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic [4:0]  sclk_div = '0;
    logic [15:0] interp_period = 16'd100;
    logic        sdin = 1'b0;
    logic        sclk;
    logic        sdfs;
    logic [15:0] samp_i;
    logic [15:0] samp_q;
    logic        samp_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // host-side model state
    int          cyc;
    int          rise_idx;
    int          n_frames;
    int          tx_frame;
    int          n_valid;
    int          last_rise;
    int          sclk_period;
    int          sdfs_start;
    int          sdfs_len;
    int          frame_cyc [16];
    logic [31:0] tx_word [8];
    logic [31:0] cur_word;
    logic        sclk_prev;
    logic        sdfs_prev;
    logic        rise;

    serial_sample_port dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep         (sleep),
        .sclk_div      (sclk_div),
        .interp_period (interp_period),
        .sdin          (sdin),
        .sclk          (sclk),
        .sdfs          (sdfs),
        .samp_i        (samp_i),
        .samp_q        (samp_q),
        .samp_valid    (samp_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Host model: drives sdin from observed sclk/sdfs and checks each capture.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; rise_idx = -1; n_frames = 0; tx_frame = 0; n_valid = 0;
            last_rise = 0; sclk_period = 0; sdfs_start = 0; sdfs_len = 0;
            sclk_prev = 1'b0; sdfs_prev = 1'b0; sdin = 1'b0; cur_word = '0;
        end else begin
            cyc++;
            rise = sclk && !sclk_prev;
            if (rise) begin
                if (last_rise != 0) sclk_period = cyc - last_rise;
                last_rise = cyc;
            end
            if (rise && sdfs && !sdfs_prev) begin
                if (n_frames < 16) frame_cyc[n_frames] = cyc;
                n_frames++;
                sdfs_start = cyc;
                rise_idx   = 0;
                cur_word   = tx_word[tx_frame % 8];
                tx_frame++;
                sdin = ~cur_word[31];
            end else if (rise && rise_idx >= 0) begin
                rise_idx++;
                if (rise_idx <= 32) sdin = cur_word[32 - rise_idx];
                else                sdin = ~sdin;
            end
            if (!sdfs && sdfs_prev) sdfs_len = cyc - sdfs_start;
            if (rise && rise_idx == 33) begin
                chk(samp_valid === 1'b1, "R7 strobe after 32nd bit", samp_valid, 1);
                chk({samp_i, samp_q} === cur_word, "R6 captured word", {samp_i, samp_q}, cur_word);
                n_valid++;
            end else if (samp_valid) begin
                chk(1'b0, "R7 strobe in wrong cycle", cyc, 0);
            end
            sclk_prev = sclk;
            sdfs_prev = sdfs;
        end
    end

    task automatic do_reset(input logic [4:0] div, input logic [15:0] per);
        @(negedge clk);
        rst_n = 1'b0;
        sleep = 1'b0;
        sclk_div = div;
        interp_period = per;
        repeat (3) @(negedge clk);
        chk(sclk === 1'b0, "R1 sclk low in reset", sclk, 0);
        chk(sdfs === 1'b0 && samp_valid === 1'b0, "R9 flags clear in reset", {sdfs, samp_valid}, 0);
        chk({samp_i, samp_q} === 32'h0, "R9 samples clear in reset", {samp_i, samp_q}, 0);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_frames(input int n, input int limit);
        int k = 0;
        while (n_frames < n && k < limit) begin @(posedge clk); k++; end
    endtask

    task automatic wait_valid(input int n, input int limit);
        int k = 0;
        while (n_valid < n && k < limit) begin @(posedge clk); k++; end
    endtask

    task automatic test_start_and_divider;
        do_reset(5'd3, 16'd400);
        for (int n = 1; n <= 9; n++) begin
            @(negedge clk);
            if (n == 1) chk(sclk === 1'b1, "R1 sclk high on first edge", sclk, 1);
            else chk(sclk === (((n - 1) / 4) % 2 == 0), "R2 half period of 4", sclk, ((n - 1) / 4) % 2 == 0);
        end
    endtask

    task automatic test_integer_ratio;
        do_reset(5'd2, 16'd240);
        wait_frames(4, 2000);
        for (int b = 0; b < 4; b++)
            chk(frame_cyc[b] == 1 + 240 * b, "R4 integer spacing", frame_cyc[b], 1 + 240 * b);
        chk(sdfs_len == 6, "R3 pulse width one sclk", sdfs_len, 6);
        chk(sclk_period == 6, "R2 sclk period", sclk_period, 6);
        wait_valid(4, 2000);
        chk(n_valid == 4, "R6 four words taken", n_valid, 4);
    endtask

    task automatic test_dither;
        do_reset(5'd0, 16'd75);
        wait_frames(6, 2000);
        for (int b = 0; b < 6; b++) begin
            int e = 1 + ((75 * b + 1) / 2) * 2;
            chk(frame_cyc[b] == e, "R4 dithered frame start", frame_cyc[b], e);
        end
        chk((frame_cyc[1] - frame_cyc[0]) != (frame_cyc[2] - frame_cyc[1]), "R4 gap alternates",
            frame_cyc[2] - frame_cyc[1], frame_cyc[1] - frame_cyc[0]);
        chk(sdfs_len == 2, "R3 pulse width one sclk", sdfs_len, 2);
    endtask

    task automatic test_extra_clocks;
        do_reset(5'd0, 16'd75);
        wait_valid(1, 1000);
        repeat (20) @(negedge clk);
        chk({samp_i, samp_q} === tx_word[0], "R8 extra sclks ignored", {samp_i, samp_q}, tx_word[0]);
        wait_valid(2, 1000);
        @(negedge clk);
        chk({samp_i, samp_q} === tx_word[1], "R8 next word after junk", {samp_i, samp_q}, tx_word[1]);
    endtask

    task automatic test_slow_divider;
        do_reset(5'd31, 16'd2176);
        wait_frames(2, 6000);
        chk(frame_cyc[1] == 1 + 2176, "R4 slow frame spacing", frame_cyc[1], 1 + 2176);
        chk(sclk_period == 64, "R2 slowest sclk", sclk_period, 64);
        wait_valid(2, 6000);
        chk(n_valid == 2, "R6 slow capture count", n_valid, 2);
    endtask

    task automatic test_sleep;
        int bad = 0;
        int v0;
        do_reset(5'd0, 16'd75);
        wait_valid(1, 1000);
        @(negedge clk);
        #1 sleep = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (sdfs !== 1'b0 || samp_valid !== 1'b0) bad++;
        end
        chk(bad == 0, "R5 quiet in sleep", bad, 0);
        v0 = n_valid;
        #1 sleep = 1'b0;
        wait_valid(v0 + 1, 400);
        chk(n_valid == v0 + 1, "R5 capture resumes after sleep", n_valid, v0 + 1);
    endtask

    initial begin
        tx_word[0] = 32'h8001_7FFE;
        tx_word[1] = 32'h1234_ABCD;
        tx_word[2] = 32'hFFFF_0000;
        tx_word[3] = 32'h0000_FFFF;
        tx_word[4] = 32'hA5A5_5A5A;
        tx_word[5] = 32'h7FFF_8000;
        tx_word[6] = 32'hC3C3_0F0F;
        tx_word[7] = 32'h0001_8000;
        test_start_and_divider();
        test_integer_ratio();
        test_dither();
        test_extra_clocks();
        test_slow_divider();
        test_sleep();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule